// File: doc/BRIEF.md
# Oversampling UART receiver

This block turns an asynchronous serial line into bytes. The line idles high. A frame is a low start bit, then the data bits with the least significant bit first, then a high stop bit. An enable pulse from outside the block, at eight times the bit rate, sets when the line is looked at. Between those pulses the receiver holds its state. The line passes through a synchroniser before any logic uses it.

A falling edge does not start a frame at once. The line must read low on four oversample ticks in a row, which lands the receiver near the middle of the start bit. From that point the receiver counts eight ticks, samples a data bit, and repeats. Each sample is therefore taken near the centre of its bit. When the stop bit reads high, the assembled byte moves into a holding register and a full flag goes up for the host.

The host clears the full flag with a data-read strobe. If a new byte lands while the previous one is still unread, the new byte replaces it and an overrun flag is raised. A status-read strobe clears the overrun flag. A frame whose stop sample is low is thrown away.

Top module: `uart_rx_os`

## Requirements
- R1: The receiver state changes only on clock cycles where `tick_x8` is high. While ticks are withheld, a low line sets no flag and receives no byte.
- R2: A start bit is accepted after four consecutive low tick samples of the synchronised line.
- R3: If any of those four start-check samples is high, the receiver goes back to idle and no byte is produced. Three low ticks followed by a high one is the boundary case.
- R4: After a start bit is accepted, the first data bit is sampled eight ticks later and each further bit eight ticks after the one before. Bits fill the byte least significant bit first, so line bit k becomes `rx_data[k]`.
- R5: When the stop sample is 1, the shifted byte appears on `rx_data` and `rx_full` is 1 from the next clock.
- R6: A `data_rd` pulse with no byte completing in the same cycle drives `rx_full` to 0 on the next clock.
- R7: When the stop sample is 0, the byte is discarded. `rx_full` and `rx_overrun` keep their values and the receiver returns to idle.
- R8: If a byte completes while `rx_full` is 1 and no `data_rd` is pending, `rx_overrun` goes to 1 and `rx_data` takes the new byte.
- R9: A `status_rd` pulse clears `rx_overrun` on the next clock. It leaves `rx_full` and `rx_data` unchanged.
- R10: After reset, `rx_full` = 0, `rx_overrun` = 0 and `rx_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| tick_x8 | input | 1 | One-cycle enable at eight times the bit rate |
| data_rd | input | 1 | Host read of the received byte; clears the full flag |
| status_rd | input | 1 | Host read of status; clears the overrun flag |
| rx_data | output | DATA_BITS | Last received byte |
| rx_full | output | 1 | An unread byte is held |
| rx_overrun | output | 1 | A byte was overwritten before it was read |

## Verification
The bench builds the block with its default parameters: eight data bits, eight ticks per bit, a four-sample start run and a two-stage synchroniser. It raises a tick every four clocks, so one frame takes a few hundred cycles. Several complete frames, a glitch and a bad stop bit all fit in a short run. Because the line is driven in whole ticks, a glitch of exactly three low ticks can be produced, and so can a stop bit that reads low at its sample point and goes high one tick later. With the bench's reads switched off, two frames in a row create an overrun, and each flag can then be cleared separately.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  // True when a counter that runs 0..lim-1 sits on its last value.
  function automatic logic at_last(input int unsigned value, input int unsigned lim);
    return value == (lim - 1);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= IDLE_LEVEL;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= IDLE_LEVEL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned OSR       = 8,
  parameter int unsigned START_RUN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_s,
  output rx_state_t            state,
  output logic                 start_accept,
  output logic                 bit_take,
  output logic                 frame_ok,
  output logic                 frame_bad,
  output logic [DATA_BITS-1:0] shreg
);

  localparam int unsigned SUBW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned BITW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rx_state_t            state_q;
  logic [SUBW-1:0]      sub_q;
  logic [BITW-1:0]      bit_q;
  logic [DATA_BITS-1:0] sh_q;

  // Insert a fresh bit at the top; after DATA_BITS shifts the first bit is at bit 0.
  function automatic logic [DATA_BITS-1:0] shift_lsb_first(
    input logic [DATA_BITS-1:0] sr, input logic b);
    return {b, sr[DATA_BITS-1:1]};
  endfunction

  logic sub_last, start_last, bit_last, stop_take;

  assign sub_last   = at_last(int'(sub_q), OSR);
  assign start_last = at_last(int'(sub_q), START_RUN);
  assign bit_last   = at_last(int'(bit_q), DATA_BITS);

  assign start_accept = tick && (state_q == RX_START) && !line_s && start_last;
  assign bit_take     = tick && (state_q == RX_DATA) && sub_last;
  assign stop_take    = tick && (state_q == RX_STOP) && sub_last;
  assign frame_ok     = stop_take && line_s;
  assign frame_bad    = stop_take && !line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else if (tick) begin
      case (state_q)
        RX_IDLE: begin
          if (!line_s) begin
            state_q <= RX_START;
            sub_q   <= SUBW'(1);
          end
        end
        RX_START: begin
          if (line_s) begin
            state_q <= RX_IDLE;
            sub_q   <= '0;
          end else if (start_last) begin
            state_q <= RX_DATA;
            sub_q   <= '0;
            bit_q   <= '0;
          end else begin
            sub_q <= sub_q + SUBW'(1);
          end
        end
        RX_DATA: begin
          if (sub_last) begin
            sub_q <= '0;
            sh_q  <= shift_lsb_first(sh_q, line_s);
            if (bit_last) state_q <= RX_STOP;
            else          bit_q   <= bit_q + BITW'(1);
          end else begin
            sub_q <= sub_q + SUBW'(1);
          end
        end
        RX_STOP: begin
          if (sub_last) begin
            sub_q   <= '0;
            state_q <= RX_IDLE;
          end else begin
            sub_q <= sub_q + SUBW'(1);
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign state = state_q;
  assign shreg = sh_q;

endmodule

// File: rtl/rx_hold_regs.sv
module rx_hold_regs #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] load_data,
  input  logic                 data_rd,
  input  logic                 status_rd,
  output logic [DATA_BITS-1:0] data_q,
  output logic                 full_q,
  output logic                 overrun_q
);

  logic ovr_set;
  assign ovr_set = load && full_q && !data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      full_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (load) data_q <= load_data;

      if (load)         full_q <= 1'b1;
      else if (data_rd) full_q <= 1'b0;

      if (ovr_set)        overrun_q <= 1'b1;
      else if (status_rd) overrun_q <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned OSR         = 8,
  parameter int unsigned START_RUN   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_serial,
  input  logic                 tick_x8,
  input  logic                 data_rd,
  input  logic                 status_rd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_full,
  output logic                 rx_overrun
);

  // Named internal events, visible to the bound checker.
  logic                 line_s;
  rx_state_t            fsm_state;
  logic                 start_accept;
  logic                 bit_take;
  logic                 frame_ok;
  logic                 frame_bad;
  logic [DATA_BITS-1:0] shreg;

  rx_sync #(
    .STAGES     (SYNC_STAGES),
    .IDLE_LEVEL (1'b1)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (rx_serial),
    .sync_out (line_s)
  );

  rx_frame_fsm #(
    .DATA_BITS (DATA_BITS),
    .OSR       (OSR),
    .START_RUN (START_RUN)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick_x8),
    .line_s       (line_s),
    .state        (fsm_state),
    .start_accept (start_accept),
    .bit_take     (bit_take),
    .frame_ok     (frame_ok),
    .frame_bad    (frame_bad),
    .shreg        (shreg)
  );

  rx_hold_regs #(
    .DATA_BITS (DATA_BITS)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_ok),
    .load_data (shreg),
    .data_rd   (data_rd),
    .status_rd (status_rd),
    .data_q    (rx_data),
    .full_q    (rx_full),
    .overrun_q (rx_overrun)
  );

endmodule

// File: rtl/uart_rx_os_chk.sv
module uart_rx_os_chk
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 line_s,
  input rx_state_t            state,
  input logic                 start_accept,
  input logic                 bit_take,
  input logic                 frame_ok,
  input logic                 frame_bad,
  input logic [DATA_BITS-1:0] shreg,
  input logic                 data_rd,
  input logic                 status_rd,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_full,
  input logic                 rx_overrun
);

  // R1
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));

  // R2
  start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> state == RX_DATA);

  // R3
  glitch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state == RX_START && line_s) |=> state == RX_IDLE);

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_take |=> shreg[DATA_BITS-1] == $past(line_s));

  // R5
  load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> rx_full && rx_data == $past(shreg));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !frame_ok) |=> !rx_full);

  // R7
  bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_bad && !rx_full) |=> !rx_full && $stable(rx_data));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && rx_full && !data_rd) |=> rx_overrun);

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !frame_ok) |=> !rx_overrun);

endmodule

bind uart_rx_os uart_rx_os_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick_x8),
  .line_s       (line_s),
  .state        (fsm_state),
  .start_accept (start_accept),
  .bit_take     (bit_take),
  .frame_ok     (frame_ok),
  .frame_bad    (frame_bad),
  .shreg        (shreg),
  .data_rd      (data_rd),
  .status_rd    (status_rd),
  .rx_data      (rx_data),
  .rx_full      (rx_full),
  .rx_overrun   (rx_overrun)
);

// File: tb/uart_rx_os_bench.sv
`timescale 1ns/1ps
module uart_rx_os_bench;

  localparam int unsigned NB = 8;
  localparam int unsigned CLK_PER_TICK = 4;
  localparam int unsigned TPB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic tick = 1'b0;
  logic tick_en = 1'b1;
  logic mon_rd = 1'b0;
  logic man_rd = 1'b0;
  logic stat_rd = 1'b0;
  logic auto_rd = 1'b0;
  logic data_rd;
  logic [NB-1:0] rx_data;
  logic rx_full, rx_overrun;

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] exp_q[$];

  assign data_rd = mon_rd | man_rd;

  always #10 clk = ~clk;

  int unsigned tdiv = 0;
  always_ff @(posedge clk) begin
    if (tdiv == CLK_PER_TICK - 1) tdiv <= 0;
    else                          tdiv <= tdiv + 1;
    tick <= tick_en && (tdiv == CLK_PER_TICK - 1);
  end

  uart_rx_os u_uart_rx_os (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_serial  (line),
    .tick_x8    (tick),
    .data_rd    (data_rd),
    .status_rd  (stat_rd),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk iff tick);
    @(negedge clk);
  endtask

  task automatic hold_line(input logic v, input int n);
    line = v;
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  // Driver: one frame; good frames may push their byte to the scoreboard.
  task automatic send_frame(input logic [NB-1:0] b, input logic good, input logic push);
    if (push) exp_q.push_back(b);
    wait_tick();
    hold_line(1'b0, TPB);
    for (int i = 0; i < NB; i++) hold_line(b[i], TPB);
    if (good) hold_line(1'b1, TPB);
    else begin
      hold_line(1'b0, 5);
      hold_line(1'b1, 3);
    end
    hold_line(1'b1, 4);
  endtask

  // Monitor: pops the expected byte when a byte is flagged, then reads it.
  initial begin
    forever begin
      @(negedge clk);
      if (auto_rd && rx_full) begin
        if (exp_q.size() == 0) check("R5 unexpected byte", 32'(rx_data), 32'hDEAD);
        else check("R4/R5 received byte", 32'(rx_data), 32'(exp_q.pop_front()));
        mon_rd = 1'b1;
        @(negedge clk);
        mon_rd = 1'b0;
        check("R6 full cleared by read", 32'(rx_full), 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R10 reset full", 32'(rx_full), 0);
    check("R10 reset overrun", 32'(rx_overrun), 0);
    check("R10 reset data", 32'(rx_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    auto_rd = 1'b1;
    send_frame(8'h55, 1'b1, 1'b1);
    send_frame(8'hA3, 1'b1, 1'b1);
    send_frame(8'h00, 1'b1, 1'b1);
    send_frame(8'hFF, 1'b1, 1'b1);
    send_frame(8'h01, 1'b1, 1'b1);
    send_frame(8'h80, 1'b1, 1'b1);
    check("R4 scoreboard drained", 32'(exp_q.size()), 0);

    // R3: three low ticks then high is a glitch
    wait_tick();
    hold_line(1'b0, 3);
    hold_line(1'b1, 90);
    check("R3 glitch gives no byte", 32'(rx_full), 0);
    send_frame(8'h5A, 1'b1, 1'b1);
    check("R3 byte after glitch", 32'(exp_q.size()), 0);

    // R1: no ticks, line low for a long time
    tick_en = 1'b0;
    repeat (8) @(negedge clk);
    line = 1'b0;
    repeat (400) @(negedge clk);
    line = 1'b1;
    repeat (8) @(negedge clk);
    tick_en = 1'b1;
    for (int i = 0; i < 90; i++) wait_tick();
    check("R1 no byte without ticks", 32'(rx_full), 0);
    send_frame(8'hC3, 1'b1, 1'b1);
    check("R1 byte after tick pause", 32'(exp_q.size()), 0);

    // R7: bad stop bit
    send_frame(8'h77, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) wait_tick();
    check("R7 bad stop no full", 32'(rx_full), 0);
    check("R7 bad stop no overrun", 32'(rx_overrun), 0);
    check("R7 data unchanged", 32'(rx_data), 32'hC3);
    send_frame(8'h3C, 1'b1, 1'b1);
    check("R7 byte after bad stop", 32'(exp_q.size()), 0);

    // R8/R9: overrun
    auto_rd = 1'b0;
    send_frame(8'h12, 1'b1, 1'b0);
    check("R5 first byte full", 32'(rx_full), 1);
    check("R8 no overrun yet", 32'(rx_overrun), 0);
    check("R5 first byte data", 32'(rx_data), 32'h12);
    send_frame(8'h34, 1'b1, 1'b0);
    check("R8 overrun set", 32'(rx_overrun), 1);
    check("R8 full held", 32'(rx_full), 1);
    check("R8 new byte replaces", 32'(rx_data), 32'h34);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R9 overrun cleared", 32'(rx_overrun), 0);
    check("R9 full untouched", 32'(rx_full), 1);
    check("R9 data untouched", 32'(rx_data), 32'h34);
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
    check("R6 manual read clears full", 32'(rx_full), 0);
    check("R6 data kept after read", 32'(rx_data), 32'h34);

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule